// File: doc/BRIEF.md
# Shared quad-SPI memory controller

This block turns processor memory requests into transfers on one quad-SPI bus. A flash device and two PSRAM devices share that bus. All three devices share the serial clock and the four data lines, and each has its own active-low chip select. A request carries a 28-bit address, a size of 1, 2 or 4 bytes and a direction. The upper address bits pick the device and the lower bits give the offset inside it. The block then sends out a command, the address, a mode byte and data four bits at a time. It waits a number of dummy clocks and collects read data the same way. At the end it raises the chip select and gives the requester a one-cycle completion pulse.

The flash is expected to be in continuous-read mode, so a flash read has no command phase. The PSRAMs run with all four lines in every phase. The number of dummy clocks is taken from data lines 2..0 while reset is low and stays fixed until the next reset. During reset the block drives none of the bus pins. Writes to flash and requests to addresses that no device decodes are completed with no bus activity.

Top module: `qspi_mem_ctrl`

## Requirements
- R1: Decode: upper nibble 0x0 (0x0000000..0x0FFFFFF) selects flash with offset addr[23:0]. 0x1000000..0x17FFFFF selects RAM A and 0x1800000..0x1FFFFFF selects RAM B, both with offset {0, addr[22:0]}. Chip selects are cs_n_o[0] flash, [1] RAM A, [2] RAM B.
- R2: At most one chip select is low at any time. All are high when idle and right after reset.
- R3: A write aimed at flash lowers no chip select and leaves the bus untouched. It still completes with a ready pulse one cycle after acceptance.
- R4: A request to an address at or above 0x2000000 is handled the same way as R3, and its read data is zero.
- R5: A flash read sends six offset nibbles, most significant first, then the mode byte 0xA0 as two nibbles, then L dummy clocks, then data. No command byte is sent.
- R6: A RAM read sends command 0xEB as two nibbles, then six offset nibbles, then L dummy clocks, then data.
- R7: A RAM write sends command 0x38, then six offset nibbles, then data at once, with no dummy clocks.
- R8: L is sampled from sd_i[2:0] on every clock edge while rst_ni is low. It is held unchanged after release. L = 0 removes the dummy phase.
- R9: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. Data moves least significant byte first, with the high nibble of each byte first. Read bytes beyond the size are returned as zero.
- R10: Each nibble takes one serial clock period of two system clocks. The data is driven while sck_o is low, and reads are sampled at the end of the sck_o high cycle. The data lines are driven during the command, offset, mode and write-data phases only. For N nibbles the chip select stays low for exactly 2N cycles, and sck_o is low whenever no chip select is low.
- R11: req_ready_o is high for exactly one cycle, the cycle after the chip select rises. It comes 2N+1 cycles after the request is accepted in idle, and rsp_rdata_o is valid in that cycle.
- R12: While rst_ni is low, ctl_oe_o and sd_oe_o are all zero, so the clock, the chip selects and the data lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; held until req_ready_o |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_addr_i | input | 28 | Request byte address |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| req_ready_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read data, valid with req_ready_o |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 3 | Active-low chip selects (flash, RAM A, RAM B) |
| ctl_oe_o | output | 1 | Output enable for sck_o and cs_n_o |
| sd_o | output | 4 | Data lines out |
| sd_oe_o | output | 4 | Data line output enables |
| sd_i | input | 4 | Data lines in; bits 2:0 give the latency in reset |

## Verification
The assertions check on every cycle the properties that hold in every state:

- one chip select at most;
- a released bus during reset;
- no serial clock while the bus is idle;
- the flash chip select never low for a write;
- the latency held after reset;
- the one-cycle ready pulse with the chip selects high.

Only the bench scenarios can show:

- the nibble order of each transfer type;
- the offset decode;
- the byte order and zero fill of read data;
- the skipped dummy phase at latency 0;
- the exact cycle count from acceptance to ready.

For these, a bench model of the devices logs every nibble and compares it with a sequence built from the requirements.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {
    DEV_FLASH = 2'd0,
    DEV_RAM_A = 2'd1,
    DEV_RAM_B = 2'd2,
    DEV_NONE  = 2'd3
  } dev_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA, ST_FIN
  } st_e;

  localparam int NUM_DEV   = 3;
  localparam int CMD_NIBS  = 2;
  localparam int ADDR_NIBS = 6;
  localparam int MODE_NIBS = 2;

  localparam logic [7:0] CMD_RAM_RD = 8'hEB;
  localparam logic [7:0] CMD_RAM_WR = 8'h38;
  localparam logic [7:0] FLASH_MODE = 8'hA0;
endpackage

// File: rtl/qspi_addr_dec.sv
module qspi_addr_dec
  import qspi_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFFS_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dev_e              dev_o,
  output logic [OFFS_W-1:0] offs_o
);
  localparam int UP_W = ADDR_W - OFFS_W;

  logic [UP_W-1:0] upper;
  assign upper = addr_i[ADDR_W-1:OFFS_W];

  always_comb begin
    dev_o  = DEV_NONE;
    offs_o = '0;
    if (upper == '0) begin
      dev_o  = DEV_FLASH;
      offs_o = addr_i[OFFS_W-1:0];
    end else if (upper == UP_W'(1)) begin
      // top offset bit splits the RAM window in two halves
      dev_o  = addr_i[OFFS_W-1] ? DEV_RAM_B : DEV_RAM_A;
      offs_o = {1'b0, addr_i[OFFS_W-2:0]};
    end
  end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int LAT_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       req_size_i,
  input  dev_e             dev_i,
  input  logic [LAT_W-1:0] lat_i,
  output st_e              st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ph_o,
  output dev_e             dev_o,
  output logic             wr_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_NIBS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(MODE_NIBS - 1);

  st_e              st_q, nxt;
  logic [CNT_W-1:0] cnt_q, last, data_last_q;
  logic             ph_q, wr_q, reject;
  dev_e             dev_q;
  st_e              after_hdr;

  assign accept_o  = (st_q == ST_IDLE) && req_valid_i;
  assign reject    = (dev_i == DEV_NONE) || (dev_i == DEV_FLASH && req_write_i);
  assign after_hdr = (lat_i == '0) ? ST_DATA : ST_DUMMY;

  always_comb begin
    last = '0;
    nxt  = ST_IDLE;
    case (st_q)
      ST_CMD:   begin last = CMD_LAST;  nxt = ST_ADDR; end
      ST_ADDR:  begin
        last = ADDR_LAST;
        if (dev_q == DEV_FLASH) nxt = ST_MODE;
        else if (wr_q)          nxt = ST_DATA;
        else                    nxt = after_hdr;
      end
      ST_MODE:  begin last = MODE_LAST; nxt = after_hdr; end
      ST_DUMMY: begin last = CNT_W'(lat_i) - CNT_W'(1); nxt = ST_DATA; end
      ST_DATA:  begin last = data_last_q; nxt = ST_FIN; end
      default:  begin last = '0; nxt = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      ph_q        <= 1'b0;
      dev_q       <= DEV_NONE;
      wr_q        <= 1'b0;
      data_last_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_o) begin
          dev_q <= dev_i;
          wr_q  <= req_write_i;
          cnt_q <= '0;
          ph_q  <= 1'b0;
          case (req_size_i)
            2'd0:    data_last_q <= CNT_W'(1);
            2'd1:    data_last_q <= CNT_W'(3);
            default: data_last_q <= CNT_W'(7);
          endcase
          if (reject)                 st_q <= ST_FIN;
          else if (dev_i == DEV_FLASH) st_q <= ST_ADDR;
          else                        st_q <= ST_CMD;
        end
        ST_FIN: st_q <= ST_IDLE;
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q == last) begin
              cnt_q <= '0;
              st_q  <= nxt;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;
  assign ph_o  = ph_q;
  assign dev_o = dev_q;
  assign wr_o  = wr_q;

  p_fin_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FIN |=> st_q == ST_IDLE);
  p_no_dummy_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DUMMY |-> !wr_q);
endmodule

// File: rtl/qspi_nibble_dp.sv
module qspi_nibble_dp
  import qspi_pkg::*;
#(
  parameter int OFFS_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  st_e               st_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ph_i,
  input  logic              wr_i,
  input  logic [3:0]        sd_i,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NIB_PER_OFFS = OFFS_W / 4;

  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [7:0]        cmd;
  int                data_bit, addr_nib;

  // byte index from cnt[2:1], high nibble on even cnt
  assign data_bit = 8 * int'(cnt_i[2:1]) + (cnt_i[0] ? 0 : 4);
  assign addr_nib = NIB_PER_OFFS - 1 - int'(cnt_i);
  assign cmd      = wr_i ? CMD_RAM_WR : CMD_RAM_RD;

  always_comb begin
    sd_o    = '0;
    sd_oe_o = '0;
    case (st_i)
      ST_CMD: begin
        sd_o    = cnt_i[0] ? cmd[3:0] : cmd[7:4];
        sd_oe_o = '1;
      end
      ST_ADDR: begin
        sd_o    = offs_q[4*addr_nib +: 4];
        sd_oe_o = '1;
      end
      ST_MODE: begin
        sd_o    = cnt_i[0] ? FLASH_MODE[3:0] : FLASH_MODE[7:4];
        sd_oe_o = '1;
      end
      ST_DATA: if (wr_i) begin
        sd_o    = wdata_q[data_bit +: 4];
        sd_oe_o = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offs_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept_i) begin
      offs_q  <= offs_i;
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (st_i == ST_DATA && !wr_i && ph_i) begin
      rdata_q[data_bit +: 4] <= sd_i;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/qspi_mem_ctrl.sv
module qspi_mem_ctrl
  import qspi_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFFS_W = 24,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              sck_o,
  output logic [2:0]        cs_n_o,
  output logic              ctl_oe_o,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  input  logic [3:0]        sd_i
);
  localparam int CNT_W = 4;

  dev_e             dec_dev, cur_dev;
  logic [OFFS_W-1:0] dec_offs;
  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic             ph, wr, accept, active, ctl_oe_q;
  logic [LAT_W-1:0] lat_q;
  logic [3:0]       dp_sd_oe;

  // latency pins are only meaningful while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) lat_q <= sd_i[LAT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_oe_q <= 1'b0;
    else         ctl_oe_q <= 1'b1;
  end

  qspi_addr_dec #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dec (
    .addr_i (req_addr_i),
    .dev_o  (dec_dev),
    .offs_o (dec_offs)
  );

  qspi_seq #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_size_i  (req_size_i),
    .dev_i       (dec_dev),
    .lat_i       (lat_q),
    .st_o        (st),
    .cnt_o       (cnt),
    .ph_o        (ph),
    .dev_o       (cur_dev),
    .wr_o        (wr),
    .accept_o    (accept)
  );

  qspi_nibble_dp #(.OFFS_W(OFFS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .offs_i   (dec_offs),
    .wdata_i  (req_wdata_i),
    .st_i     (st),
    .cnt_i    (cnt),
    .ph_i     (ph),
    .wr_i     (wr),
    .sd_i     (sd_i),
    .sd_o     (sd_o),
    .sd_oe_o  (dp_sd_oe),
    .rdata_o  (rsp_rdata_o)
  );

  assign active = (st != ST_IDLE) && (st != ST_FIN);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign cs_n_o[g] = !(active && cur_dev == dev_e'(g));
  end

  assign sck_o       = active && ph;
  assign ctl_oe_o    = ctl_oe_q;
  assign sd_oe_o     = ctl_oe_q ? dp_sd_oe : 4'h0;
  assign req_ready_o = (st == ST_FIN);

  p_single_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);
  p_flash_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o[0] |-> !wr);
  p_sck_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o == 3'b111 |-> !sck_o);
  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_n_o == 3'b111 ##1 !req_ready_o);
  p_lat_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !ctl_oe_q)
    $stable(lat_q));
  p_released_in_reset_r12: assert property (@(posedge clk_i)
    !rst_ni |-> (sd_oe_o == 4'h0 && !ctl_oe_o));
endmodule

// File: tb/qspi_mem_ctrl_tb_top.sv
module qspi_mem_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_write_i;
  logic [1:0]  req_size_i;
  logic [27:0] req_addr_i;
  logic [31:0] req_wdata_i;
  logic        req_ready_o, sck_o, ctl_oe_o;
  logic [31:0] rsp_rdata_o;
  logic [2:0]  cs_n_o;
  logic [3:0]  sd_o, sd_oe_o, sd_i;

  int checks = 0;
  int errors = 0;

  qspi_mem_ctrl dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_size_i, .req_addr_i,
    .req_wdata_i, .req_ready_o, .rsp_rdata_o, .sck_o, .cs_n_o, .ctl_oe_o,
    .sd_o, .sd_oe_o, .sd_i
  );

  always #2 clk_i = ~clk_i;

  // device model state
  int          lat_cfg = 2;
  logic [31:0] mem_word = '0;
  int          k = 0;
  int          low_tot [3] = '{0, 0, 0};
  int          multi_cs = 0;
  logic [3:0]  log_nib [64];
  logic [3:0]  log_oe  [64];

  function automatic logic [3:0] model_nib(int idx);
    int j;
    j = idx - (8 + lat_cfg);
    if (j < 0 || j > 7) return 4'h0;
    return mem_word[8*(j/2) + ((j%2) ? 0 : 4) +: 4];
  endfunction

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      sd_i <= 4'(lat_cfg);
      k = 0;
    end else begin
      for (int d = 0; d < 3; d++) if (!cs_n_o[d]) low_tot[d]++;
      if ($countones(~cs_n_o) > 1) multi_cs++;
      if (cs_n_o == 3'b111) k = 0;
      else if (sck_o) begin
        if (k < 64) begin
          log_nib[k] = sd_o;
          log_oe[k]  = sd_oe_o;
        end
        sd_i <= model_nib(k);
        k++;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset(int lat);
    lat_cfg     = lat;
    rst_ni      = 1'b0;
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
    req_size_i  = '0;
    req_addr_i  = '0;
    req_wdata_i = '0;
    repeat (4) @(negedge clk_i);
    chk(sd_oe_o == 4'h0 && !ctl_oe_o, "R12 released in reset",
        {27'd0, ctl_oe_o, sd_oe_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cs_n_o == 3'b111 && !sck_o && !req_ready_o && ctl_oe_o,
        "R2 idle after reset", {27'd0, cs_n_o, sck_o, req_ready_o},
        {27'd0, 3'b111, 2'b00});
  endtask

  // runs one request and checks bus sequence, timing and data
  task automatic do_txn(bit wr, logic [27:0] addr, logic [1:0] sz,
                        logic [31:0] wd, int dev, string tag);
    logic [3:0] exp_nib [40];
    logic [3:0] exp_oe  [40];
    logic [23:0] offs;
    logic [7:0]  cmd;
    int n = 0, nbytes, waits = 0, bad = 0, bad_i = -1;
    int lo_before [3];
    int lo_diff;
    logic [31:0] mask, exp_rd;

    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mask   = (nbytes == 1) ? 32'hFF : (nbytes == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    offs   = (dev == 0) ? addr[23:0] : {1'b0, addr[22:0]};
    if (dev > 0) begin
      cmd = wr ? 8'h38 : 8'hEB;
      exp_nib[n] = cmd[7:4]; exp_oe[n] = 4'hF; n++;
      exp_nib[n] = cmd[3:0]; exp_oe[n] = 4'hF; n++;
    end
    if (dev >= 0) begin
      for (int i = 5; i >= 0; i--) begin
        exp_nib[n] = offs[4*i +: 4]; exp_oe[n] = 4'hF; n++;
      end
      if (dev == 0) begin
        exp_nib[n] = 4'hA; exp_oe[n] = 4'hF; n++;
        exp_nib[n] = 4'h0; exp_oe[n] = 4'hF; n++;
      end
      if (!wr) for (int i = 0; i < lat_cfg; i++) begin
        exp_nib[n] = 4'h0; exp_oe[n] = 4'h0; n++;
      end
      for (int j = 0; j < 2*nbytes; j++) begin
        exp_nib[n] = wr ? wd[8*(j/2) + ((j%2) ? 0 : 4) +: 4] : 4'h0;
        exp_oe[n]  = wr ? 4'hF : 4'h0;
        n++;
      end
    end

    for (int d = 0; d < 3; d++) lo_before[d] = low_tot[d];
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_addr_i  = addr;
    req_size_i  = sz;
    req_wdata_i = wd;
    do begin
      @(negedge clk_i);
      waits++;
    end while (!req_ready_o && waits < 200);
    exp_rd = (dev > 0 || (dev == 0 && !wr)) ? (mem_word & mask) : 32'd0;
    if (!wr) chk(rsp_rdata_o == exp_rd, {tag, " R9 read data"}, rsp_rdata_o, exp_rd);
    req_valid_i = 1'b0;
    chk(waits == 2*n + 1, {tag, " R11 ready cycle"}, waits, 2*n + 1);

    for (int d = 0; d < 3; d++) begin
      lo_diff = low_tot[d] - lo_before[d];
      chk(lo_diff == ((d == dev) ? 2*n : 0), {tag, " R1 R10 cs low cycles"},
          lo_diff, (d == dev) ? 2*n : 0);
    end
    if (dev >= 0) begin
      for (int i = 0; i < n; i++)
        if (log_oe[i] !== exp_oe[i] || (exp_oe[i] != 0 && log_nib[i] !== exp_nib[i])) begin
          bad++;
          if (bad_i < 0) bad_i = i;
        end
      if (bad_i < 0) bad_i = 0;
      chk(bad == 0, {tag, " nibble sequence"},
          {log_oe[bad_i], log_nib[bad_i]}, {exp_oe[bad_i], exp_nib[bad_i]});
    end
    @(negedge clk_i);
  endtask

  task automatic t_flash_read;
    mem_word = 32'hC3B2_A190;
    do_txn(1'b0, 28'h0123456, 2'd2, '0, 0, "R5 flash read 4B");
  endtask

  task automatic t_ram_reads;
    mem_word = 32'h1122_3344;
    do_txn(1'b0, 28'h1000010, 2'd0, '0, 1, "R6 ramA read 1B");
    mem_word = 32'h5E6F_7A8B;
    do_txn(1'b0, 28'h1FFFFFE, 2'd1, '0, 2, "R6 ramB read 2B");
  endtask

  task automatic t_ram_writes;
    do_txn(1'b1, 28'h1ABCDEF, 2'd1, 32'h0000_BEEF, 2, "R7 ramB write 2B");
    do_txn(1'b1, 28'h1234567, 2'd3, 32'hDEAD_1234, 1, "R7 ramA write 4B");
  endtask

  task automatic t_ignored;
    do_txn(1'b1, 28'h0000100, 2'd2, 32'h1234_5678, -1, "R3 flash write");
    mem_word = 32'hFFFF_FFFF;
    do_txn(1'b0, 28'h2000000, 2'd2, '0, -1, "R4 unmapped read");
    do_txn(1'b0, 28'h8000004, 2'd0, '0, -1, "R4 unmapped read hi");
  endtask

  task automatic t_latency;
    apply_reset(3);
    mem_word = 32'h0F1E_2D3C;
    do_txn(1'b0, 28'h0FFFFFC, 2'd2, '0, 0, "R8 lat3 flash");
    do_txn(1'b0, 28'h17FFFFF, 2'd0, '0, 1, "R8 lat3 ramA");
    apply_reset(0);
    mem_word = 32'h9876_5432;
    do_txn(1'b0, 28'h0000008, 2'd1, '0, 0, "R8 lat0 flash");
    do_txn(1'b0, 28'h1800000, 2'd2, '0, 2, "R8 lat0 ramB");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply_reset(2);
    t_flash_read();
    t_ram_reads();
    t_ram_writes();
    t_ignored();
    t_latency();
    chk(multi_cs == 0, "R2 single chip select", multi_cs, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule